// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Channel Pair

This block moves words between a peripheral and memory over two independent channels. The receive channel takes a word from the peripheral and writes it to memory. The transmit channel reads a word from memory and hands it to the peripheral. Each channel holds an active buffer, made of an address pointer and a word count, and a queued follow-on buffer of the same shape. When the active count runs out on an enabled channel and a follow-on buffer is queued, the follow-on pair moves into the active pair in the same clock edge, so back-to-back buffers stream without an idle cycle.

Software programs the pointers and counts through a simple register port. It starts and stops each channel through a write-only command word and reads the run state back from a status word. Every peripheral request pulse on a running channel with words left causes exactly one memory access, using a valid/ready handshake. Each channel has at most one access in flight. Two flags per channel go to the interrupt logic. The end flag means the active buffer has drained. The exhausted flag means both the active and the queued buffer are empty.

Top module: `pdma_pair`

## Requirements
- R1: After reset every pointer and count reads zero, both channels are stopped, all four flags are low and no memory access is requested.
- R2: Register offsets: receive pointer 0x100, receive count 0x104, transmit pointer 0x108, transmit count 0x10C, and the queued copies of these at 0x110, 0x114, 0x118 and 0x11C. Pointers hold 32 bits and counts hold the low 16 bits of the written word. All of them read back at their own offsets.
- R3: A write to 0x120 starts receive with bit 0, stops receive with bit 1, starts transmit with bit 8 and stops transmit with bit 9. When start and stop for one channel arrive in the same write, the channel ends up stopped. Offset 0x124 reads the receive run state in bit 0 and the transmit run state in bit 8, with every other bit zero.
- R4: A request accepted on a running channel with a nonzero count is acknowledged in its cycle and issues one memory access at the current pointer. When that access completes, the pointer grows by the transfer size (4 bytes by default) and the count drops by one.
- R5: The receive channel writes the request's data word to memory and signals completion. The transmit channel reads memory and presents the returned word on its data output, with a one-cycle valid pulse in the cycle after the memory handshake.
- R6: While an access is outstanding, the request stays asserted with a stable address until it is accepted, and further peripheral requests are ignored without acknowledgement.
- R7: When a running channel's active count is zero and its queued count is nonzero, the queued pointer and count replace the active ones and the queued count becomes zero. When the last word's completion triggers this, it happens on the same edge.
- R8: A completion that brings the active count to zero sets that channel's end flag. This includes the case where a queued buffer is then chained in.
- R9: A completion that brings the active count to zero while the queued count is zero sets that channel's exhausted flag.
- R10: Writing a nonzero active count clears both that channel's flags. Writing a nonzero queued count clears only its exhausted flag.
- R11: Writes to unmapped offsets change nothing. Reads of unmapped offsets and of the command word at 0x120 return zero.
- R12: Stopping a channel with an access in flight lets that access complete and update the pointer and count. No chaining happens while the channel is stopped, and no new request is accepted.
- R13: Requests on a stopped channel, or on a running channel whose active count is zero, are not acknowledged and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| rx_req | input | 1 | Receive request pulse from the peripheral |
| rx_data | input | DATA_W | Receive word from the peripheral |
| rx_ack | output | 1 | Receive request accepted |
| rx_done | output | 1 | Receive word written to memory (pulse) |
| rx_end | output | 1 | Receive active buffer drained |
| rx_full | output | 1 | Receive active and queued buffers exhausted |
| rx_mem_valid | output | 1 | Receive memory write request |
| rx_mem_addr | output | PTR_W | Receive memory byte address |
| rx_mem_wdata | output | DATA_W | Receive memory write data |
| rx_mem_ready | input | 1 | Receive memory write accepted |
| tx_req | input | 1 | Transmit request pulse from the peripheral |
| tx_ack | output | 1 | Transmit request accepted |
| tx_done | output | 1 | Transmit word valid on tx_data (pulse) |
| tx_data | output | DATA_W | Transmit word to the peripheral |
| tx_end | output | 1 | Transmit active buffer drained |
| tx_full | output | 1 | Transmit active and queued buffers exhausted |
| tx_mem_valid | output | 1 | Transmit memory read request |
| tx_mem_addr | output | PTR_W | Transmit memory byte address |
| tx_mem_ready | input | 1 | Transmit memory read completes |
| tx_mem_rdata | input | DATA_W | Transmit memory read data, valid with ready |

## Verification
The bench targets the chaining edge, where the last completion must load the queued buffer on the same edge and set the end flag but not the exhausted flag. A design that chained one cycle late, or raised the wrong flag, would drift from the reference model on that cycle. It also targets a stop command that arrives while a memory read is stalled. A faulty design would drop the access, skip the count update, or chain a queued buffer while stopped. Other targets are the start/stop collision in one command word, a second request during an outstanding access, the selective clearing of the flags by nonzero count writes, and the truncation of the count field to 16 bits. Each of these shows up as a wrong readback value or a wrong acknowledge.

// File: rtl/pdma_pkg.sv
`timescale 1ns/1ps
package pdma_pkg;
   localparam int NCH    = 2;
   localparam int CH_RX  = 0;
   localparam int CH_TX  = 1;

   localparam logic [31:0] OFS_BANK_LO = 32'h100;
   localparam logic [31:0] OFS_CMD     = 32'h120;
   localparam logic [31:0] OFS_STAT    = 32'h124;

   // command and status bit of channel c is at c*CMD_STRIDE
   localparam int CMD_START  = 0;
   localparam int CMD_STOP   = 1;
   localparam int CMD_STRIDE = 8;

   typedef struct packed {
      logic ptr;
      logic cnt;
      logic nptr;
      logic ncnt;
   } wr_sel_t;
endpackage

// File: rtl/pdma_regif.sv
`timescale 1ns/1ps
module pdma_regif #(
   parameter int REG_AW = 12,
   parameter int PTR_W  = 32,
   parameter int CNT_W  = 16
) (
   input  logic                                reg_we,
   input  logic [REG_AW-1:0]                   reg_addr,
   input  logic [31:0]                         reg_wdata,
   output logic [31:0]                         reg_rdata,
   output pdma_pkg::wr_sel_t [pdma_pkg::NCH-1:0] wr_sel,
   output logic [pdma_pkg::NCH-1:0]            en_set,
   output logic [pdma_pkg::NCH-1:0]            en_clr,
   input  logic [pdma_pkg::NCH-1:0]            ch_en,
   input  logic [pdma_pkg::NCH-1:0][PTR_W-1:0] act_ptr,
   input  logic [pdma_pkg::NCH-1:0][CNT_W-1:0] act_cnt,
   input  logic [pdma_pkg::NCH-1:0][PTR_W-1:0] nxt_ptr,
   input  logic [pdma_pkg::NCH-1:0][CNT_W-1:0] nxt_cnt
);
   import pdma_pkg::*;

   logic [31:0] ofs;
   logic        in_bank;
   logic        cmd_we;

   assign ofs     = 32'(reg_addr);
   assign in_bank = (ofs[31:5] == OFS_BANK_LO[31:5]) && (ofs[1:0] == 2'b00);
   assign cmd_we  = reg_we && (ofs == OFS_CMD);

   for (genvar c = 0; c < NCH; c++) begin : g_dec
      logic hit;
      assign hit            = reg_we && in_bank && (ofs[3] == 1'(c));
      assign wr_sel[c].ptr  = hit && !ofs[4] && !ofs[2];
      assign wr_sel[c].cnt  = hit && !ofs[4] &&  ofs[2];
      assign wr_sel[c].nptr = hit &&  ofs[4] && !ofs[2];
      assign wr_sel[c].ncnt = hit &&  ofs[4] &&  ofs[2];
      assign en_set[c]      = cmd_we && reg_wdata[c*CMD_STRIDE + CMD_START];
      assign en_clr[c]      = cmd_we && reg_wdata[c*CMD_STRIDE + CMD_STOP];
   end

   always_comb begin
      reg_rdata = '0;
      if (in_bank) begin
         unique case ({ofs[4], ofs[2]})
            2'b00:   reg_rdata = 32'(act_ptr[ofs[3]]);
            2'b01:   reg_rdata = 32'(act_cnt[ofs[3]]);
            2'b10:   reg_rdata = 32'(nxt_ptr[ofs[3]]);
            default: reg_rdata = 32'(nxt_cnt[ofs[3]]);
         endcase
      end else if (ofs == OFS_STAT) begin
         for (int c = 0; c < NCH; c++) begin
            reg_rdata[c*CMD_STRIDE] = ch_en[c];
         end
      end
   end
endmodule

// File: rtl/pdma_chan.sv
`timescale 1ns/1ps
module pdma_chan #(
   parameter int PTR_W      = 32,
   parameter int CNT_W      = 16,
   parameter int DATA_W     = 32,
   parameter int XFER_BYTES = 4,
   parameter bit IS_RX      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  pdma_pkg::wr_sel_t wr_sel,
   input  logic [PTR_W-1:0]  wr_data,
   input  logic              en_set,
   input  logic              en_clr,
   input  logic              req,
   output logic              req_ack,
   input  logic [DATA_W-1:0] xfer_in,
   output logic [DATA_W-1:0] xfer_out,
   output logic              done,
   output logic              m_valid,
   output logic [PTR_W-1:0]  m_addr,
   input  logic              m_ready,
   output logic              en,
   output logic              end_flag,
   output logic              full_flag,
   output logic [PTR_W-1:0]  act_ptr,
   output logic [CNT_W-1:0]  act_cnt,
   output logic [PTR_W-1:0]  nxt_ptr,
   output logic [CNT_W-1:0]  nxt_cnt
);
   localparam logic [PTR_W-1:0] STEP    = PTR_W'(XFER_BYTES);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [PTR_W-1:0]  ptr_q, ptr_d, nptr_q, nptr_d, addr_q;
   logic [CNT_W-1:0]  cnt_q, cnt_d, ncnt_q, ncnt_d;
   logic [CNT_W-1:0]  wr_cnt_val;
   logic [DATA_W-1:0] data_q;
   logic              en_q, busy_q, end_q, full_q, done_q;
   logic              end_d, full_d;
   logic              accept, finish;

   assign accept     = en_q && !busy_q && (cnt_q != '0) && req;
   assign finish     = busy_q && m_ready;
   assign wr_cnt_val = wr_data[CNT_W-1:0];

   always_comb begin
      ptr_d  = ptr_q;
      cnt_d  = cnt_q;
      nptr_d = nptr_q;
      ncnt_d = ncnt_q;
      end_d  = end_q;
      full_d = full_q;
      if (finish && (cnt_q != '0)) begin
         ptr_d = ptr_q + STEP;
         cnt_d = cnt_q - CNT_ONE;
         if (cnt_d == '0) begin
            end_d = 1'b1;
            if (ncnt_q == '0) full_d = 1'b1;
         end
      end
      if (en_q && (cnt_d == '0) && (ncnt_q != '0)) begin
         ptr_d  = nptr_q;
         cnt_d  = ncnt_q;
         ncnt_d = '0;
      end
      if (wr_sel.ptr)  ptr_d  = wr_data;
      if (wr_sel.nptr) nptr_d = wr_data;
      if (wr_sel.cnt) begin
         cnt_d = wr_cnt_val;
         if (wr_cnt_val != '0) begin
            end_d  = 1'b0;
            full_d = 1'b0;
         end
      end
      if (wr_sel.ncnt) begin
         ncnt_d = wr_cnt_val;
         if (wr_cnt_val != '0) full_d = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         cnt_q  <= '0;
         nptr_q <= '0;
         ncnt_q <= '0;
         end_q  <= 1'b0;
         full_q <= 1'b0;
         en_q   <= 1'b0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         addr_q <= '0;
      end else begin
         ptr_q  <= ptr_d;
         cnt_q  <= cnt_d;
         nptr_q <= nptr_d;
         ncnt_q <= ncnt_d;
         end_q  <= end_d;
         full_q <= full_d;
         en_q   <= (en_q | en_set) & ~en_clr;
         done_q <= finish;
         if (accept) begin
            busy_q <= 1'b1;
            addr_q <= ptr_q;
         end else if (finish) begin
            busy_q <= 1'b0;
         end
      end
   end

   // data path direction chosen by parameter
   if (IS_RX) begin : g_rx_data
      always_ff @(posedge clk) begin
         if (!rst_n)      data_q <= '0;
         else if (accept) data_q <= xfer_in;
      end
   end else begin : g_tx_data
      always_ff @(posedge clk) begin
         if (!rst_n)      data_q <= '0;
         else if (finish) data_q <= xfer_in;
      end
   end

   assign req_ack   = accept;
   assign xfer_out  = data_q;
   assign done      = done_q;
   assign m_valid   = busy_q;
   assign m_addr    = addr_q;
   assign en        = en_q;
   assign end_flag  = end_q;
   assign full_flag = full_q;
   assign act_ptr   = ptr_q;
   assign act_cnt   = cnt_q;
   assign nxt_ptr   = nptr_q;
   assign nxt_cnt   = ncnt_q;

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_addr)));

   assert_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |=> (m_valid && m_addr == $past(act_ptr)));

   assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && m_ready && act_cnt > CNT_ONE && !wr_sel.cnt && !wr_sel.ptr)
      |=> (act_cnt == $past(act_cnt) - CNT_ONE && act_ptr == $past(act_ptr) + STEP));

   assert_end_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(end_flag) |-> $past(m_valid && m_ready));

   assert_chain_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && act_cnt == '0 && nxt_cnt != '0 && !m_valid && wr_sel == '0)
      |=> (act_cnt == $past(nxt_cnt) && act_ptr == $past(nxt_ptr) && nxt_cnt == '0));

   assert_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      en_clr |=> !en);
endmodule

// File: rtl/pdma_pair.sv
`timescale 1ns/1ps
module pdma_pair #(
   parameter int REG_AW     = 12,
   parameter int PTR_W      = 32,
   parameter int CNT_W      = 16,
   parameter int DATA_W     = 32,
   parameter int XFER_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              rx_req,
   input  logic [DATA_W-1:0] rx_data,
   output logic              rx_ack,
   output logic              rx_done,
   output logic              rx_end,
   output logic              rx_full,
   output logic              rx_mem_valid,
   output logic [PTR_W-1:0]  rx_mem_addr,
   output logic [DATA_W-1:0] rx_mem_wdata,
   input  logic              rx_mem_ready,
   input  logic              tx_req,
   output logic              tx_ack,
   output logic              tx_done,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_end,
   output logic              tx_full,
   output logic              tx_mem_valid,
   output logic [PTR_W-1:0]  tx_mem_addr,
   input  logic              tx_mem_ready,
   input  logic [DATA_W-1:0] tx_mem_rdata
);
   import pdma_pkg::*;

   if (!(XFER_BYTES == 1 || XFER_BYTES == 2 || XFER_BYTES == 4)) begin : g_bad_xfer
      $error("XFER_BYTES must be 1, 2 or 4");
   end
   if (DATA_W < 8 * XFER_BYTES) begin : g_bad_data
      $error("DATA_W narrower than one transfer");
   end
   if (PTR_W > 32 || PTR_W < CNT_W) begin : g_bad_ptr
      $error("PTR_W must be within CNT_W..32");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("CNT_W must be within 1..32");
   end
   if (REG_AW < 9 || REG_AW > 32) begin : g_bad_aw
      $error("REG_AW must be within 9..32");
   end

   wr_sel_t [NCH-1:0]             wr_sel;
   logic [NCH-1:0]                en_set, en_clr, ch_en;
   logic [NCH-1:0]                req, ack, done, m_valid, m_ready, end_f, full_f;
   logic [NCH-1:0][DATA_W-1:0]    xin, xout;
   logic [NCH-1:0][PTR_W-1:0]     m_addr, act_ptr, nxt_ptr;
   logic [NCH-1:0][CNT_W-1:0]     act_cnt, nxt_cnt;

   pdma_regif #(.REG_AW(REG_AW), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_regif (
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .wr_sel    (wr_sel),
      .en_set    (en_set),
      .en_clr    (en_clr),
      .ch_en     (ch_en),
      .act_ptr   (act_ptr),
      .act_cnt   (act_cnt),
      .nxt_ptr   (nxt_ptr),
      .nxt_cnt   (nxt_cnt)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      pdma_chan #(
         .PTR_W(PTR_W), .CNT_W(CNT_W), .DATA_W(DATA_W),
         .XFER_BYTES(XFER_BYTES), .IS_RX(c == CH_RX)
      ) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_sel    (wr_sel[c]),
         .wr_data   (reg_wdata[PTR_W-1:0]),
         .en_set    (en_set[c]),
         .en_clr    (en_clr[c]),
         .req       (req[c]),
         .req_ack   (ack[c]),
         .xfer_in   (xin[c]),
         .xfer_out  (xout[c]),
         .done      (done[c]),
         .m_valid   (m_valid[c]),
         .m_addr    (m_addr[c]),
         .m_ready   (m_ready[c]),
         .en        (ch_en[c]),
         .end_flag  (end_f[c]),
         .full_flag (full_f[c]),
         .act_ptr   (act_ptr[c]),
         .act_cnt   (act_cnt[c]),
         .nxt_ptr   (nxt_ptr[c]),
         .nxt_cnt   (nxt_cnt[c])
      );
   end

   assign req[CH_RX]     = rx_req;
   assign req[CH_TX]     = tx_req;
   assign xin[CH_RX]     = rx_data;
   assign xin[CH_TX]     = tx_mem_rdata;
   assign m_ready[CH_RX] = rx_mem_ready;
   assign m_ready[CH_TX] = tx_mem_ready;

   assign rx_ack       = ack[CH_RX];
   assign rx_done      = done[CH_RX];
   assign rx_end       = end_f[CH_RX];
   assign rx_full      = full_f[CH_RX];
   assign rx_mem_valid = m_valid[CH_RX];
   assign rx_mem_addr  = m_addr[CH_RX];
   assign rx_mem_wdata = xout[CH_RX];
   assign tx_ack       = ack[CH_TX];
   assign tx_done      = done[CH_TX];
   assign tx_data      = xout[CH_TX];
   assign tx_end       = end_f[CH_TX];
   assign tx_full      = full_f[CH_TX];
   assign tx_mem_valid = m_valid[CH_TX];
   assign tx_mem_addr  = m_addr[CH_TX];

   assert_stat_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(reg_addr) == OFS_STAT) |-> ((reg_rdata & ~32'h0000_0101) == '0));

   assert_cmd_rd_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(reg_addr) == OFS_CMD) |-> (reg_rdata == '0));

   assert_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_mem_valid && tx_mem_ready) |=> (tx_done && tx_data == $past(tx_mem_rdata)));
endmodule

// File: tb/pdma_pair_tb.sv
`timescale 1ns/1ps
module pdma_pair_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        rx_req = 1'b0;
   logic [31:0] rx_data = '0;
   logic        rx_ack, rx_done, rx_end, rx_full, rx_mem_valid;
   logic [31:0] rx_mem_addr, rx_mem_wdata;
   logic        rx_mem_ready = 1'b0;
   logic        tx_req = 1'b0;
   logic        tx_ack, tx_done, tx_end, tx_full, tx_mem_valid;
   logic [31:0] tx_data, tx_mem_addr, tx_mem_rdata;
   logic        tx_mem_ready = 1'b0;
   logic        tx_stall = 1'b0;

   int n_chk = 0, n_fail = 0, cyc = 0, ack_cnt = 0;
   logic [31:0] last_tx = '0;

   always #2.5 clk = ~clk;

   pdma_pair u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .rx_req(rx_req), .rx_data(rx_data), .rx_ack(rx_ack), .rx_done(rx_done),
      .rx_end(rx_end), .rx_full(rx_full), .rx_mem_valid(rx_mem_valid),
      .rx_mem_addr(rx_mem_addr), .rx_mem_wdata(rx_mem_wdata), .rx_mem_ready(rx_mem_ready),
      .tx_req(tx_req), .tx_ack(tx_ack), .tx_done(tx_done), .tx_data(tx_data),
      .tx_end(tx_end), .tx_full(tx_full), .tx_mem_valid(tx_mem_valid),
      .tx_mem_addr(tx_mem_addr), .tx_mem_ready(tx_mem_ready), .tx_mem_rdata(tx_mem_rdata)
   );

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return a ^ 32'hC3C3_0000;
   endfunction
   assign tx_mem_rdata = mem_word(tx_mem_addr);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [31:0] m_ptr[2], m_nptr[2], m_addr[2], m_dat[2];
   int          m_cnt[2], m_ncnt[2];
   bit          m_en[2], m_busy[2], m_end[2], m_full[2], m_done[2];

   function automatic logic [31:0] model_read(input logic [11:0] a);
      int ch;
      ch = a[3];
      if (a >= 12'h100 && a <= 12'h11C && a[1:0] == 2'b00) begin
         case ({a[4], a[2]})
            2'b00:   return m_ptr[ch];
            2'b01:   return 32'(m_cnt[ch]);
            2'b10:   return m_nptr[ch];
            default: return 32'(m_ncnt[ch]);
         endcase
      end
      if (a == 12'h124) return {23'd0, m_en[1], 7'd0, m_en[0]};
      return 32'h0;
   endfunction

   task automatic model_reset();
      for (int c = 0; c < 2; c++) begin
         m_ptr[c] = 0; m_nptr[c] = 0; m_addr[c] = 0; m_dat[c] = 0;
         m_cnt[c] = 0; m_ncnt[c] = 0; m_en[c] = 0; m_busy[c] = 0;
         m_end[c] = 0; m_full[c] = 0; m_done[c] = 0;
      end
   endtask

   task automatic model_step();
      for (int c = 0; c < 2; c++) begin
         bit rq, rdy, acc, fin;
         int base;
         logic [31:0] old_ptr;
         rq  = (c == 0) ? rx_req : tx_req;
         rdy = (c == 0) ? rx_mem_ready : tx_mem_ready;
         acc = m_en[c] && !m_busy[c] && m_cnt[c] != 0 && rq;
         fin = m_busy[c] && rdy;
         old_ptr = m_ptr[c];
         if (acc) ack_cnt++;
         m_done[c] = fin;
         if (fin && c == 1) m_dat[c] = mem_word(m_addr[c]);
         if (acc && c == 0) m_dat[c] = rx_data;
         if (fin && m_cnt[c] != 0) begin
            m_ptr[c] = m_ptr[c] + 32'd4;
            m_cnt[c] = m_cnt[c] - 1;
            if (m_cnt[c] == 0) begin
               m_end[c] = 1;
               if (m_ncnt[c] == 0) m_full[c] = 1;
            end
         end
         if (m_en[c] && m_cnt[c] == 0 && m_ncnt[c] != 0) begin
            m_ptr[c] = m_nptr[c]; m_cnt[c] = m_ncnt[c]; m_ncnt[c] = 0;
         end
         if (acc) begin m_busy[c] = 1; m_addr[c] = old_ptr; end
         else if (fin) m_busy[c] = 0;
         base = 12'h100 + 8 * c;
         if (reg_we) begin
            if (reg_addr == 12'(base))      m_ptr[c] = reg_wdata;
            if (reg_addr == 12'(base + 16)) m_nptr[c] = reg_wdata;
            if (reg_addr == 12'(base + 4)) begin
               m_cnt[c] = reg_wdata[15:0];
               if (m_cnt[c] != 0) begin m_end[c] = 0; m_full[c] = 0; end
            end
            if (reg_addr == 12'(base + 20)) begin
               m_ncnt[c] = reg_wdata[15:0];
               if (m_ncnt[c] != 0) m_full[c] = 0;
            end
            if (reg_addr == 12'h120) begin
               if (reg_wdata[8*c]) m_en[c] = 1;
               if (reg_wdata[8*c+1]) m_en[c] = 0;
            end
         end
      end
   endtask

   // compare every cycle just before the rising edge, then advance the model
   initial begin
      model_reset();
      forever begin
         @(negedge clk);
         #2;
         if (!rst_n) model_reset();
         else begin
            chk("R6 rx_mem_valid", 32'(rx_mem_valid), 32'(m_busy[0]));
            chk("R6 tx_mem_valid", 32'(tx_mem_valid), 32'(m_busy[1]));
            if (m_busy[0]) begin
               chk("R4 rx_mem_addr", rx_mem_addr, m_addr[0]);
               chk("R5 rx_mem_wdata", rx_mem_wdata, m_dat[0]);
            end
            if (m_busy[1]) chk("R4 tx_mem_addr", tx_mem_addr, m_addr[1]);
            chk("R4 rx_ack", 32'(rx_ack), 32'(m_en[0] && !m_busy[0] && m_cnt[0] != 0 && rx_req));
            chk("R4 tx_ack", 32'(tx_ack), 32'(m_en[1] && !m_busy[1] && m_cnt[1] != 0 && tx_req));
            chk("R5 rx_done", 32'(rx_done), 32'(m_done[0]));
            chk("R5 tx_done", 32'(tx_done), 32'(m_done[1]));
            if (m_done[1]) begin
               chk("R5 tx_data", tx_data, m_dat[1]);
               last_tx = tx_data;
            end
            chk("R8 rx_end", 32'(rx_end), 32'(m_end[0]));
            chk("R8 tx_end", 32'(tx_end), 32'(m_end[1]));
            chk("R9 rx_full", 32'(rx_full), 32'(m_full[0]));
            chk("R9 tx_full", 32'(tx_full), 32'(m_full[1]));
            chk("R2 reg_rdata", reg_rdata, model_read(reg_addr));
            model_step();
         end
      end
   end

   // memory ready patterns
   always @(negedge clk) begin
      cyc <= cyc + 1;
      rx_mem_ready <= (cyc % 3 == 2);
      tx_mem_ready <= !tx_stall && (cyc % 2 == 1);
   end

   // ---------------- stimulus tasks ----------------
   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk(tag, reg_rdata, exp);
   endtask

   task automatic pulse(input bit is_tx, input logic [31:0] d);
      @(negedge clk);
      if (is_tx) tx_req = 1'b1; else begin rx_req = 1'b1; rx_data = d; end
      @(negedge clk);
      tx_req = 1'b0; rx_req = 1'b0;
   endtask

   task automatic wait_idle();
      repeat (2) @(negedge clk);
      while (rx_mem_valid || tx_mem_valid) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hang expected completion");
      summary();
      $finish;
   end

   initial begin
      int acks;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      for (int a = 12'h100; a <= 12'h124; a += 4) rd(12'(a), 32'h0, "R1 reset register");
      chk("R1 reset flags", {28'd0, rx_end, rx_full, tx_end, tx_full}, 32'h0);
      chk("R1 reset no request", {30'd0, rx_mem_valid, tx_mem_valid}, 32'h0);

      // R2 map and widths
      wr(12'h100, 32'h0000_1000);
      wr(12'h104, 32'h0001_2345);
      rd(12'h104, 32'h0000_2345, "R2 count is 16 bits");
      wr(12'h104, 32'd3);
      wr(12'h108, 32'h0000_2000);
      wr(12'h10C, 32'd2);
      wr(12'h110, 32'h0000_3000);
      wr(12'h114, 32'd2);
      wr(12'h118, 32'h0000_4000);
      rd(12'h100, 32'h0000_1000, "R2 receive pointer");
      rd(12'h110, 32'h0000_3000, "R2 receive queued pointer");
      rd(12'h114, 32'd2, "R2 receive queued count");
      rd(12'h118, 32'h0000_4000, "R2 transmit queued pointer");
      rd(12'h10C, 32'd2, "R2 transmit count");

      // R11 unmapped accesses
      wr(12'h128, 32'hFFFF_FFFF);
      wr(12'h12C, 32'hFFFF_FFFF);
      rd(12'h128, 32'h0, "R11 unmapped read");
      rd(12'h120, 32'h0, "R11 command reads zero");
      rd(12'h100, 32'h0000_1000, "R11 pointer untouched");
      rd(12'h124, 32'h0, "R11 no channel started");

      // R3 command/status
      wr(12'h120, 32'h0000_0003);
      rd(12'h124, 32'h0, "R3 stop wins on receive");
      wr(12'h120, 32'h0000_0303);
      rd(12'h124, 32'h0, "R3 stop wins on both");
      wr(12'h120, 32'h0000_0101);
      rd(12'h124, 32'h0000_0101, "R3 both started");
      wr(12'h120, 32'h0000_0200);
      rd(12'h124, 32'h0000_0001, "R3 transmit stopped");

      // R6 second request during an outstanding access is dropped
      acks = ack_cnt;
      @(negedge clk); rx_req = 1'b1; rx_data = 32'hAAAA_0001;
      @(negedge clk); rx_data = 32'hAAAA_0002;
      @(negedge clk); rx_req = 1'b0;
      wait_idle();
      chk("R6 one acknowledge", 32'(ack_cnt - acks), 32'd1);
      rd(12'h104, 32'd2, "R6 count dropped by one");
      rd(12'h100, 32'h0000_1004, "R4 pointer advanced");

      // R7/R8 chaining at the end of the active buffer
      pulse(1'b0, 32'hAAAA_0003); wait_idle();
      pulse(1'b0, 32'hAAAA_0004); wait_idle();
      rd(12'h100, 32'h0000_3000, "R7 pointer chained");
      rd(12'h104, 32'd2, "R7 count chained");
      rd(12'h114, 32'd0, "R7 queued count cleared");
      chk("R8 end set on chain", 32'(rx_end), 32'd1);
      chk("R9 not exhausted on chain", 32'(rx_full), 32'd0);
      pulse(1'b0, 32'hAAAA_0005); wait_idle();
      pulse(1'b0, 32'hAAAA_0006); wait_idle();
      rd(12'h100, 32'h0000_3008, "R4 pointer after second buffer");
      chk("R9 exhausted", 32'(rx_full), 32'd1);

      // R13 zero count and stopped channel
      acks = ack_cnt;
      pulse(1'b0, 32'hBBBB_0000); wait_idle();
      chk("R13 no ack at zero count", 32'(ack_cnt - acks), 32'd0);
      rd(12'h100, 32'h0000_3008, "R13 pointer unchanged");
      wr(12'h104, 32'd1);
      chk("R10 active count clears end", 32'(rx_end), 32'd0);
      chk("R10 active count clears exhausted", 32'(rx_full), 32'd0);
      wr(12'h120, 32'h0000_0002);
      pulse(1'b0, 32'hBBBB_0001); wait_idle();
      chk("R13 no ack when stopped", 32'(ack_cnt - acks), 32'd0);
      rd(12'h104, 32'd1, "R13 count unchanged");

      // R5 transmit reads
      wr(12'h120, 32'h0000_0100);
      pulse(1'b1, 32'h0); wait_idle();
      chk("R5 first transmit word", last_tx, 32'hC3C3_2000);
      pulse(1'b1, 32'h0); wait_idle();
      chk("R5 second transmit word", last_tx, 32'hC3C3_2004);
      rd(12'h10C, 32'd0, "R4 transmit count drained");
      chk("R9 transmit exhausted", {30'd0, tx_end, tx_full}, 32'd3);

      // R10 queued count clears only exhausted, then chains
      wr(12'h11C, 32'd1);
      chk("R10 queued write keeps end", 32'(tx_end), 32'd1);
      chk("R10 queued write clears exhausted", 32'(tx_full), 32'd0);
      rd(12'h10C, 32'd1, "R7 idle chain count");
      rd(12'h108, 32'h0000_4000, "R7 idle chain pointer");
      wr(12'h10C, 32'd3);
      chk("R10 active write clears end", 32'(tx_end), 32'd0);

      // R12 stop while a read is stalled
      wr(12'h118, 32'h0000_5000);
      wr(12'h11C, 32'd5);
      wr(12'h10C, 32'd1);
      tx_stall = 1'b1;
      pulse(1'b1, 32'h0);
      wr(12'h120, 32'h0000_0200);
      rd(12'h124, 32'h0, "R12 stopped while busy");
      chk("R12 access still pending", 32'(tx_mem_valid), 32'd1);
      tx_stall = 1'b0;
      wait_idle();
      rd(12'h10C, 32'd0, "R12 count updated");
      rd(12'h108, 32'h0000_4004, "R12 pointer updated");
      rd(12'h11C, 32'd5, "R12 no chain while stopped");
      acks = ack_cnt;
      pulse(1'b1, 32'h0); wait_idle();
      chk("R12 no new request", 32'(ack_cnt - acks), 32'd0);
      wr(12'h120, 32'h0000_0100);
      rd(12'h10C, 32'd5, "R7 chain after restart");
      rd(12'h108, 32'h0000_5000, "R7 pointer after restart");

      repeat (4) @(negedge clk);
      summary();
      $finish;
   end
endmodule